// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Code Register

This block keeps the digital codes for two converter channels. Each channel has two registers in series. The first is a staging register, loaded by decoded write strobes that arrive from a serial front end. The second is an output register that drives the converter. Each write strobe carries:

- a channel-select bit;
- a straight-binary code, where all zeros is the lowest output and all ones is full scale minus one LSB;
- a two-bit mode field;
- a buffer-enable bit.

The fields travel together as one word.

The staged values are moved into the output registers by an active-low load input, which may be asynchronous to the system clock. The block first passes that input through a synchronizer. While the synchronized load is inactive, the output registers hold their values and the staging registers can be rewritten freely. While it is active, the path is transparent. Staging both channels and then lowering load makes both outputs change on the same clock edge.

Each channel keeps a pending flag. An output register is reloaded only when its staging register has been written since that channel's last transfer, so a channel that was not written sees no activity on its outputs.

Top module: `dual_update_reg`

## Requirements
- R1: A synchronous active-high reset clears every staging register, output register and pending flag, so all output codes, modes and buffer bits read zero after reset.
- R2: A write strobe loads only the staging register named by the select bit (0 = channel A, 1 = channel B); the other channel's staging contents are left as they were.
- R3: While the synchronized load is inactive (load_n high), every output port holds its value, whatever writes occur.
- R4: When load_n falls, it passes a two-flop synchronizer. Pending staged words reach the output ports on the third rising edge after load_n is first sampled low, and not earlier. Both channels change on that same edge.
- R5: While the synchronized load is active, a write appears at the selected channel's outputs right after the edge that captures it. If a write and a transfer coincide, the newly written word is the one transferred.
- R6: A channel's output register changes only if that channel was written since its last transfer; a load with nothing pending leaves the channel's outputs unchanged.
- R7: The mode field and the buffer bit of a write move through staging and output registers together with the code, so they appear on the outputs on the same edge as the code.
- R8: Codes pass unmodified over the full range, including all zeros and all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe from the serial decoder |
| wr_sel | input | 1 | Channel select: 0 = A, 1 = B |
| wr_code | input | CODE_W | Straight-binary code to stage |
| wr_mode | input | MODE_W | Mode field to stage |
| wr_buf | input | 1 | Buffer-enable bit to stage |
| load_n | input | 1 | Active-low load request, asynchronous |
| a_code | output | CODE_W | Channel A output code |
| a_mode | output | MODE_W | Channel A mode field |
| a_buf | output | 1 | Channel A buffer-enable bit |
| b_code | output | CODE_W | Channel B output code |
| b_mode | output | MODE_W | Channel B mode field |
| b_buf | output | 1 | Channel B buffer-enable bit |

## Verification
The assertions assume the following about the inputs:

- wr_en is a one-cycle strobe.
- wr_sel, wr_code, wr_mode and wr_buf are valid whenever wr_en is high.
- load_n, although it is asynchronous, stays at each level for several clocks.

The properties are written against the synchronized load level, not the raw pin, so a load change is judged only once it has crossed the synchronizer. The stimulus changes every input on the falling clock edge and holds load_n low for at least four cycles. After load_n rises, the stimulus waits three cycles before the next write, so the bench always knows whether the transparent window is open when it predicts an output.

// File: rtl/dual_update_pkg.sv
package dual_update_pkg;
  localparam int NUM_CH = 2;

  typedef enum logic {
    SEL_A = 1'b0,
    SEL_B = 1'b1
  } chan_sel_e;

  // Reset level of the load synchronizer: inactive (high) so no spurious transfer
  localparam logic LOAD_IDLE = 1'b1;
endpackage

// File: rtl/dual_update_sync.sv
module dual_update_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RST_VAL}};
    else     chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/dual_update_chan.sv
module dual_update_chan #(
  parameter int WORD_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              xfer_en,
  output logic [WORD_W-1:0] out_word,
  output logic              pend_o
);
  logic [WORD_W-1:0] stage_q;
  logic [WORD_W-1:0] out_q;
  logic              pend_q;
  logic              take;

  // A transfer happens only when something new is staged or arriving now
  assign take = xfer_en && (pend_q || wr_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      out_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (wr_hit) stage_q <= wr_word;
      if (take)   out_q   <= wr_hit ? wr_word : stage_q;
      if (xfer_en)     pend_q <= 1'b0;
      else if (wr_hit) pend_q <= 1'b1;
    end
  end

  assign out_word = out_q;
  assign pend_o   = pend_q;
endmodule

// File: rtl/dual_update_reg.sv
module dual_update_reg #(
  parameter int CODE_W      = 12,
  parameter int MODE_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic              wr_buf,
  input  logic              load_n,
  output logic [CODE_W-1:0] a_code,
  output logic [MODE_W-1:0] a_mode,
  output logic              a_buf,
  output logic [CODE_W-1:0] b_code,
  output logic [MODE_W-1:0] b_mode,
  output logic              b_buf
);
  import dual_update_pkg::*;

  localparam int WORD_W = CODE_W + MODE_W + 1;

  logic              load_s;
  logic              load_act;
  logic [WORD_W-1:0] wr_word;
  logic [NUM_CH-1:0] pend_vec;
  logic [WORD_W-1:0] out_word [NUM_CH];

  dual_update_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(LOAD_IDLE)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .din (load_n),
    .dout(load_s)
  );

  assign load_act = ~load_s;
  assign wr_word  = {wr_mode, wr_buf, wr_code};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = wr_en && (wr_sel == ((g == 0) ? SEL_A : SEL_B));

    dual_update_chan #(
      .WORD_W(WORD_W)
    ) u_chan (
      .clk     (clk),
      .rst     (rst),
      .wr_hit  (hit),
      .wr_word (wr_word),
      .xfer_en (load_act),
      .out_word(out_word[g]),
      .pend_o  (pend_vec[g])
    );
  end

  assign {a_mode, a_buf, a_code} = out_word[0];
  assign {b_mode, b_buf, b_code} = out_word[1];
endmodule

// File: rtl/dual_update_reg_chk.sv
module dual_update_reg_chk #(
  parameter int CODE_W = 12,
  parameter int MODE_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [CODE_W-1:0] wr_code,
  input logic [CODE_W-1:0] a_code,
  input logic [MODE_W-1:0] a_mode,
  input logic              a_buf,
  input logic [CODE_W-1:0] b_code,
  input logic [MODE_W-1:0] b_mode,
  input logic              b_buf,
  input logic              load_act,
  input logic [1:0]        pend_vec
);
  logic wr_a, wr_b;
  logic wrote_a, wrote_b;

  assign wr_a = wr_en && !wr_sel;
  assign wr_b = wr_en &&  wr_sel;

  // Independent record of "written since last transfer", per channel
  always_ff @(posedge clk) begin
    if (rst) begin
      wrote_a <= 1'b0;
      wrote_b <= 1'b0;
    end else begin
      wrote_a <= load_act ? 1'b0 : (wrote_a || wr_a);
      wrote_b <= load_act ? 1'b0 : (wrote_b || wr_b);
    end
  end

  // R1
  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (a_code == '0 && b_code == '0 && a_mode == '0 && b_mode == '0 && !a_buf && !b_buf));

  // R3
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !load_act |=> ($stable(a_code) && $stable(b_code) && $stable(a_mode) &&
                   $stable(b_mode) && $stable(a_buf) && $stable(b_buf)));

  // R4
  p_pend_clear_r4: assert property (@(posedge clk) disable iff (rst)
    load_act |=> (pend_vec == 2'b00));

  // R5
  p_follow_a_r5: assert property (@(posedge clk) disable iff (rst)
    (load_act && wr_a) |=> (a_code == $past(wr_code)));

  p_follow_b_r5: assert property (@(posedge clk) disable iff (rst)
    (load_act && wr_b) |=> (b_code == $past(wr_code)));

  // R6
  p_quiet_a_r6: assert property (@(posedge clk) disable iff (rst)
    (!wrote_a && !wr_a) |=> ($stable(a_code) && $stable(a_mode) && $stable(a_buf)));

  p_quiet_b_r6: assert property (@(posedge clk) disable iff (rst)
    (!wrote_b && !wr_b) |=> ($stable(b_code) && $stable(b_mode) && $stable(b_buf)));
endmodule

bind dual_update_reg dual_update_reg_chk #(
  .CODE_W(CODE_W),
  .MODE_W(MODE_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_sel  (wr_sel),
  .wr_code (wr_code),
  .a_code  (a_code),
  .a_mode  (a_mode),
  .a_buf   (a_buf),
  .b_code  (b_code),
  .b_mode  (b_mode),
  .b_buf   (b_buf),
  .load_act(load_act),
  .pend_vec(pend_vec)
);

// File: tb/dual_update_reg_bench.sv
`timescale 1ns/1ps
module dual_update_reg_bench;
  localparam int CODE_W = 12;
  localparam int MODE_W = 2;
  localparam int WORD_W = CODE_W + MODE_W + 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic              wr_sel = 1'b0;
  logic [CODE_W-1:0] wr_code = '0;
  logic [MODE_W-1:0] wr_mode = '0;
  logic              wr_buf = 1'b0;
  logic              load_n = 1'b1;
  logic [CODE_W-1:0] a_code, b_code;
  logic [MODE_W-1:0] a_mode, b_mode;
  logic              a_buf, b_buf;

  always #2 clk = ~clk;

  dual_update_reg #(.CODE_W(CODE_W), .MODE_W(MODE_W)) u_dual_update_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_code(wr_code),
    .wr_mode(wr_mode), .wr_buf(wr_buf), .load_n(load_n),
    .a_code(a_code), .a_mode(a_mode), .a_buf(a_buf),
    .b_code(b_code), .b_mode(b_mode), .b_buf(b_buf)
  );

  typedef struct {
    int                due;
    bit                ch;
    logic [WORD_W-1:0] w;
    string             tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit open_win = 1'b0;
  logic [WORD_W-1:0] stage_m [2];
  logic [WORD_W-1:0] out_m   [2];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push_exp(int due, bit ch, logic [WORD_W-1:0] w, string tag);
    exp_t e;
    int pos;
    e.due = due; e.ch = ch; e.w = w; e.tag = tag;
    pos = q.size();
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].due > due) begin pos = i; break; end
    end
    q.insert(pos, e);
  endtask

  // Monitor: compare due items against the ports on the falling edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      logic [WORD_W-1:0] got;
      e = q.pop_front();
      got = e.ch ? {b_mode, b_buf, b_code} : {a_mode, a_buf, a_code};
      n_cmp++;
      if (got !== e.w) begin
        n_bad++;
        $display("FAIL %s ch%0d got %h expected %h (cycle %0d)", e.tag, e.ch, got, e.w, cyc);
      end
    end
  end

  task automatic expect_both(int due, string tag);
    push_exp(due, 1'b0, out_m[0], tag);
    push_exp(due, 1'b1, out_m[1], tag);
  endtask

  task automatic do_reset(string tag);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 2; i++) begin stage_m[i] = '0; out_m[i] = '0; end
    expect_both(cyc + 1, tag);
    @(negedge clk);
  endtask

  task automatic do_write(bit ch, logic [CODE_W-1:0] code, logic [MODE_W-1:0] mode,
                          bit bf, string tag);
    logic [WORD_W-1:0] w;
    w = {mode, bf, code};
    wr_en = 1'b1; wr_sel = ch; wr_code = code; wr_mode = mode; wr_buf = bf;
    stage_m[ch] = w;
    if (open_win) out_m[ch] = w;
    expect_both(cyc + 1, tag);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_load(int hold, string tag);
    int c;
    c = cyc;
    load_n = 1'b0;
    expect_both(c + 2, {tag, " (R4 not before third edge)"});
    out_m[0] = stage_m[0];
    out_m[1] = stage_m[1];
    expect_both(c + 3, tag);
    repeat (hold) @(negedge clk);
    load_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic open_load();
    load_n = 1'b0;
    repeat (3) @(negedge clk);
    out_m[0] = stage_m[0];
    out_m[1] = stage_m[1];
    open_win = 1'b1;
    expect_both(cyc + 1, "R4 transfer on open window");
    @(negedge clk);
  endtask

  task automatic close_load();
    load_n = 1'b1;
    repeat (3) @(negedge clk);
    open_win = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R1..all got hang expected completion");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin stage_m[i] = '0; out_m[i] = '0; end
    @(negedge clk);
    do_reset("R1 reset clears outputs");

    // Staging while load is idle: outputs must hold
    do_write(1'b0, 12'h123, 2'd1, 1'b1, "R3 hold during write A");
    do_write(1'b1, 12'hABC, 2'd2, 1'b0, "R3 hold during write B");
    repeat (2) @(negedge clk);
    expect_both(cyc + 1, "R3 outputs idle after staging");
    @(negedge clk);

    // Simultaneous update with fields
    pulse_load(4, "R4 R7 both channels update together");

    // Only A staged: B keeps its value, full-scale code
    do_write(1'b0, 12'hFFF, 2'd3, 1'b0, "R8 R2 stage full scale on A");
    pulse_load(4, "R6 R2 A reloads, B untouched");

    // Load with nothing pending
    pulse_load(4, "R6 load with nothing pending");

    // Transparent window
    open_load();
    do_write(1'b1, 12'h000, 2'd2, 1'b1, "R5 R8 zero code passes through on B");
    do_write(1'b0, 12'h5A5, 2'd0, 1'b1, "R5 write A follows");
    do_write(1'b1, 12'h7E1, 2'd1, 1'b0, "R5 back-to-back write B");
    repeat (2) @(negedge clk);
    expect_both(cyc + 1, "R6 quiet window keeps outputs");
    @(negedge clk);
    close_load();

    // Last write wins while idle
    do_write(1'b0, 12'h0F0, 2'd2, 1'b0, "R3 first stage A");
    do_write(1'b0, 12'h90F, 2'd1, 1'b1, "R2 R3 overwrite stage A");
    pulse_load(5, "R7 R2 last staged word on A");

    // Reset mid-run
    do_write(1'b1, 12'h3C3, 2'd3, 1'b1, "R3 stage B before reset");
    do_reset("R1 reset after activity");
    pulse_load(4, "R1 R6 staging cleared by reset");

    repeat (4) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule